// File: doc/BRIEF.md
# Serial Command Token and Response Engine

This host-side engine drives one serial command line. A start strobe latches a 6-bit command index, a 32-bit argument and a response kind. The engine then sends a 48-bit token one bit per clock, most significant bit first, and computes its 7-bit CRC on the fly. When the command expects an answer, the engine releases the line and waits for the device. It takes the first low bit as the start of the reply and shifts the reply in until the frame is complete. Then it reports what it decoded.

The reply is one of three kinds. A short reply is 48 bits; the engine checks its CRC and compares the echoed index with the index sent. A short reply with no check carries an all-ones CRC field, and the engine checks neither the CRC nor the index. A long reply is 136 bits and yields the 127 register bits it carries. A reply that does not begin within the wait window ends the command with a timeout. Every command finishes with a single-cycle done pulse. The results stay valid until the next command is accepted.

Top module: `cmd_token_engine`

## Requirements
- R1: An accepted command puts a 48-bit token on `cmd_o`, MSB first, starting the cycle after `start_i` is sampled. Its layout is: bit 47 = 0 (start), bit 46 = 1 (host direction), bits 45:40 = index, bits 39:8 = argument, bits 7:1 = CRC, bit 0 = 1 (end). `cmd_oe_o` is high for exactly those 48 cycles.
- R2: The token CRC is a 7-bit CRC with generator x^7+x^3+1 and a zero initial value. It is computed over token bits 47:8, MSB first.
- R3: While the engine is not transmitting, `cmd_oe_o` is 0 and `cmd_o` is 1, including during and right after reset.
- R4: `rsp_kind_i` is encoded as 0 = none, 1 = short checked, 2 = short unchecked, 3 = long. With kind 0, `done_o` rises in the cycle `cmd_oe_o` falls, and the engine returns to idle without sampling `cmd_i`.
- R5: After the token, `cmd_i` is sampled once per clock. The first 0 sampled is the reply start bit. If 64 samples in a row are all 1, the command ends with `done_o` and `timeout_o` = 1, and the error flags stay 0.
- R6: Kind 1 takes 48 bits. `rsp_idx_o` = reply bits 45:40, and `rsp_data_o` = reply bits 39:8 zero-extended. `crc_err_o` = 1 when reply bits 7:1 differ from the R2 CRC of reply bits 47:8. `idx_err_o` = 1 when the echoed index differs from the index sent.
- R7: Kind 2 takes 48 bits and decodes the fields as in R6. It never raises `crc_err_o` or `idx_err_o`.
- R8: Kind 3 takes 136 bits. `rsp_data_o` = reply bits 127:1, `rsp_idx_o` = 0, and no error flag is raised.
- R9: `done_o` is a single-cycle pulse that appears one cycle after the final reply bit is sampled. All result outputs are held until the next accepted start, which clears them to 0.
- R10: `start_i` is ignored while `busy_o` is 1. The token in flight, the index used for the echo check and the results are all unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command start strobe |
| cmd_idx_i | input | 6 | Command index |
| cmd_arg_i | input | 32 | Command argument |
| rsp_kind_i | input | 2 | Expected reply kind (0 none, 1 short, 2 short unchecked, 3 long) |
| cmd_o | output | 1 | Serial command line output value |
| cmd_oe_o | output | 1 | Line drive enable |
| cmd_i | input | 1 | Serial command line input value |
| busy_o | output | 1 | Command or reply in progress |
| done_o | output | 1 | Command complete pulse |
| rsp_idx_o | output | 6 | Echoed index of a short reply |
| rsp_data_o | output | 127 | Reply payload |
| crc_err_o | output | 1 | Reply CRC mismatch |
| idx_err_o | output | 1 | Echoed index mismatch |
| timeout_o | output | 1 | No reply start within the wait window |

## Verification
The hardest cases to reach from the ports are the edges of the wait window and an attempt to start a new command while one is in flight. The bench sweeps the reply delay through every value from 0 to 63 idle cycles, then holds the line high for the full window to force a timeout. It raises a second start with a different index in the middle of a token. It then confirms that the token on the wire and the later echo check both still use the first index. Every command index is sent once, so the token CRC is compared against a CRC the bench computes for each of them.

// File: rtl/cte_pkg.sv
package cte_pkg;
   typedef enum logic [1:0] {
      RSP_NONE      = 2'd0,
      RSP_SHORT     = 2'd1,
      RSP_SHORT_RAW = 2'd2,
      RSP_LONG      = 2'd3
   } rsp_kind_e;
endpackage

// File: rtl/cte_crc_serial.sv
// Bit-serial CRC register; the generator polynomial is a parameter.
module cte_crc_serial #(
   parameter int            CRC_W    = 7,
   parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             din_i,
   output logic [CRC_W-1:0] crc_o
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] crc_nxt;
   logic             fb;

   assign fb = din_i ^ crc_q[CRC_W-1];

   for (genvar i = 0; i < CRC_W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
         assign crc_nxt[i] = fb & CRC_POLY[i];
      end else begin : g_mid
         assign crc_nxt[i] = crc_q[i-1] ^ (fb & CRC_POLY[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     crc_q <= '0;
      else if (clr_i) crc_q <= '0;
      else if (en_i)  crc_q <= crc_nxt;
   end

   assign crc_o = crc_q;
endmodule

// File: rtl/cte_tx.sv
// Token serializer: start, direction, index, argument, CRC, end.
module cte_tx #(
   parameter int               IDX_W    = 6,
   parameter int               ARG_W    = 32,
   parameter int               CRC_W    = 7,
   parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [ARG_W-1:0] arg_i,
   output logic             line_o,
   output logic             oe_o,
   output logic             last_o
);
   localparam int SPAN    = 2 + IDX_W + ARG_W;
   localparam int TOK_LEN = SPAN + CRC_W + 1;
   localparam int CW      = $clog2(TOK_LEN);
   localparam int SW      = $clog2(CRC_W);

   logic            active_q;
   logic [CW-1:0]   cnt_q;
   logic [SPAN-1:0] sr_q;
   logic [CRC_W-1:0] crc;
   logic [CW-1:0]   crc_off;
   logic            in_body;
   logic            in_crc;

   assign in_body = cnt_q < CW'(SPAN);
   assign in_crc  = !in_body && (cnt_q < CW'(TOK_LEN - 1));
   assign last_o  = active_q && (cnt_q == CW'(TOK_LEN - 1));
   assign crc_off = CW'(TOK_LEN - 2) - cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         sr_q     <= '0;
      end else if (load_i) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         sr_q     <= {1'b0, 1'b1, idx_i, arg_i};
      end else if (active_q) begin
         cnt_q <= cnt_q + 1'b1;
         sr_q  <= {sr_q[SPAN-2:0], 1'b0};
         if (last_o) active_q <= 1'b0;
      end
   end

   cte_crc_serial #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (load_i),
      .en_i  (active_q && in_body),
      .din_i (sr_q[SPAN-1]),
      .crc_o (crc)
   );

   always_comb begin
      if (!active_q)    line_o = 1'b1;
      else if (in_body) line_o = sr_q[SPAN-1];
      else if (in_crc)  line_o = crc[crc_off[SW-1:0]];
      else              line_o = 1'b1;
   end

   assign oe_o = active_q;
endmodule

// File: rtl/cte_rx.sv
// Reply receiver: start-bit hunt with timeout, capture, decode, checks.
module cte_rx
   import cte_pkg::*;
#(
   parameter int               IDX_W      = 6,
   parameter int               ARG_W      = 32,
   parameter int               CRC_W      = 7,
   parameter logic [CRC_W-1:0] CRC_POLY   = 7'h09,
   parameter int               LONG_LEN   = 136,
   parameter int               TMO_CYCLES = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_i,
   input  logic                      arm_i,
   input  rsp_kind_e                 kind_i,
   input  logic [IDX_W-1:0]          sent_idx_i,
   input  logic                      line_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic                      timeout_o,
   output logic                      crc_err_o,
   output logic                      idx_err_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [LONG_LEN-IDX_W-4:0] data_o
);
   localparam int SPAN      = 2 + IDX_W + ARG_W;
   localparam int SHORT_LEN = SPAN + CRC_W + 1;
   localparam int LONG_PAY  = LONG_LEN - IDX_W - 3;
   localparam int RCW       = $clog2(LONG_LEN);
   localparam int TCW       = $clog2(TMO_CYCLES);
   localparam int IDX_TOP   = SHORT_LEN - 3;
   localparam int ARG_TOP   = IDX_TOP - IDX_W;

   typedef enum logic [1:0] {R_IDLE, R_WAIT, R_CAP} rx_state_e;

   rx_state_e         state_q;
   logic [RCW-1:0]    rcnt_q;
   logic [TCW-1:0]    tmo_q;
   logic [LONG_LEN-1:0] frame_q;
   logic [LONG_LEN-1:0] frame_nxt;
   logic [CRC_W-1:0]  crc;
   logic              last_bit;
   logic              crc_en;
   logic              is_long;

   assign is_long   = (kind_i == RSP_LONG);
   assign frame_nxt = {frame_q[LONG_LEN-2:0], line_i};
   assign last_bit  = is_long ? (rcnt_q == RCW'(LONG_LEN - 1))
                              : (rcnt_q == RCW'(SHORT_LEN - 1));
   assign crc_en    = ((state_q == R_WAIT) && !line_i) ||
                      ((state_q == R_CAP) && (rcnt_q < RCW'(SPAN)));

   cte_crc_serial #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (arm_i),
      .en_i  (crc_en),
      .din_i (line_i),
      .crc_o (crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= R_IDLE;
         rcnt_q    <= '0;
         tmo_q     <= '0;
         frame_q   <= '0;
         done_o    <= 1'b0;
         timeout_o <= 1'b0;
         crc_err_o <= 1'b0;
         idx_err_o <= 1'b0;
         idx_o     <= '0;
         data_o    <= '0;
      end else begin
         done_o <= 1'b0;
         if (clr_i) begin
            timeout_o <= 1'b0;
            crc_err_o <= 1'b0;
            idx_err_o <= 1'b0;
            idx_o     <= '0;
            data_o    <= '0;
         end
         unique case (state_q)
            R_IDLE: begin
               if (arm_i) begin
                  state_q <= R_WAIT;
                  tmo_q   <= '0;
               end
            end
            R_WAIT: begin
               if (!line_i) begin
                  state_q <= R_CAP;
                  rcnt_q  <= RCW'(1);
                  frame_q <= frame_nxt;
               end else if (tmo_q == TCW'(TMO_CYCLES - 1)) begin
                  state_q   <= R_IDLE;
                  done_o    <= 1'b1;
                  timeout_o <= 1'b1;
               end else begin
                  tmo_q <= tmo_q + 1'b1;
               end
            end
            R_CAP: begin
               frame_q <= frame_nxt;
               rcnt_q  <= rcnt_q + 1'b1;
               if (last_bit) begin
                  state_q <= R_IDLE;
                  done_o  <= 1'b1;
                  if (is_long) begin
                     idx_o  <= '0;
                     data_o <= frame_nxt[LONG_PAY:1];
                  end else begin
                     idx_o     <= frame_nxt[IDX_TOP -: IDX_W];
                     data_o    <= LONG_PAY'(frame_nxt[ARG_TOP -: ARG_W]);
                     crc_err_o <= (kind_i == RSP_SHORT) &&
                                  (frame_nxt[CRC_W:1] != crc);
                     idx_err_o <= (kind_i == RSP_SHORT) &&
                                  (frame_nxt[IDX_TOP -: IDX_W] != sent_idx_i);
                  end
               end
            end
            default: state_q <= R_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != R_IDLE);
endmodule

// File: rtl/cmd_token_engine.sv
module cmd_token_engine
   import cte_pkg::*;
#(
   parameter int               IDX_W      = 6,
   parameter int               ARG_W      = 32,
   parameter int               CRC_W      = 7,
   parameter logic [CRC_W-1:0] CRC_POLY   = 7'h09,
   parameter int               LONG_LEN   = 136,
   parameter int               TMO_CYCLES = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [IDX_W-1:0]          cmd_idx_i,
   input  logic [ARG_W-1:0]          cmd_arg_i,
   input  logic [1:0]                rsp_kind_i,
   output logic                      cmd_o,
   output logic                      cmd_oe_o,
   input  logic                      cmd_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic [IDX_W-1:0]          rsp_idx_o,
   output logic [LONG_LEN-IDX_W-4:0] rsp_data_o,
   output logic                      crc_err_o,
   output logic                      idx_err_o,
   output logic                      timeout_o
);
   localparam int SHORT_LEN = 2 + IDX_W + ARG_W + CRC_W + 1;

   if (CRC_W < 2 || CRC_W > 16) begin : g_bad_crc
      $error("cmd_token_engine: CRC_W out of range");
   end
   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("cmd_token_engine: TMO_CYCLES must be at least 2");
   end
   if (LONG_LEN <= SHORT_LEN) begin : g_bad_len
      $error("cmd_token_engine: LONG_LEN must exceed the short frame");
   end

   logic             accept;
   logic             tx_last;
   logic             rx_busy;
   logic             rx_done;
   logic             done_none_q;
   rsp_kind_e        kind_q;
   logic [IDX_W-1:0] idx_q;

   assign busy_o = cmd_oe_o | rx_busy;
   assign accept = start_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q      <= RSP_NONE;
         idx_q       <= '0;
         done_none_q <= 1'b0;
      end else begin
         done_none_q <= tx_last && (kind_q == RSP_NONE);
         if (accept) begin
            kind_q <= rsp_kind_e'(rsp_kind_i);
            idx_q  <= cmd_idx_i;
         end
      end
   end

   cte_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .idx_i  (cmd_idx_i),
      .arg_i  (cmd_arg_i),
      .line_o (cmd_o),
      .oe_o   (cmd_oe_o),
      .last_o (tx_last)
   );

   cte_rx #(
      .IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY),
      .LONG_LEN(LONG_LEN), .TMO_CYCLES(TMO_CYCLES)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (accept),
      .arm_i      (tx_last && (kind_q != RSP_NONE)),
      .kind_i     (kind_q),
      .sent_idx_i (idx_q),
      .line_i     (cmd_i),
      .busy_o     (rx_busy),
      .done_o     (rx_done),
      .timeout_o  (timeout_o),
      .crc_err_o  (crc_err_o),
      .idx_err_o  (idx_err_o),
      .idx_o      (rsp_idx_o),
      .data_o     (rsp_data_o)
   );

   assign done_o = done_none_q | rx_done;
endmodule

// File: rtl/cte_checker.sv
module cte_checker #(
   parameter int PAY_W   = 127,
   parameter int TOK_LEN = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             cmd_o,
   input logic             cmd_oe_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [PAY_W-1:0] rsp_data_o,
   input logic             crc_err_o,
   input logic             idx_err_o,
   input logic             timeout_o
);
   logic [7:0] oe_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        oe_len_q <= '0;
      else if (cmd_oe_o) oe_len_q <= oe_len_q + 1'b1;
      else               oe_len_q <= '0;
   end

   p_token_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe_o) |-> (oe_len_q == 8'(TOK_LEN)));

   p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_oe_o) |-> !cmd_o);

   p_end_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_oe_o) |-> $past(cmd_o));

   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_oe_o |-> cmd_o);

   p_none_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cmd_oe_o) && !busy_o) |-> done_o);

   p_timeout_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!crc_err_o && !idx_err_o));

   p_err_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(crc_err_o) || $rose(idx_err_o)) |-> done_o);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(rsp_data_o) && $stable(timeout_o)));
endmodule

bind cmd_token_engine cte_checker #(.PAY_W(LONG_LEN-IDX_W-3), .TOK_LEN(SHORT_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .cmd_o      (cmd_o),
   .cmd_oe_o   (cmd_oe_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .rsp_data_o (rsp_data_o),
   .crc_err_o  (crc_err_o),
   .idx_err_o  (idx_err_o),
   .timeout_o  (timeout_o)
);

// File: tb/cmd_token_engine_test.sv
module cmd_token_engine_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [5:0]   cmd_idx_i = '0;
   logic [31:0]  cmd_arg_i = '0;
   logic [1:0]   rsp_kind_i = '0;
   logic         cmd_o, cmd_oe_o, busy_o, done_o;
   logic         cmd_i = 1'b1;
   logic [5:0]   rsp_idx_o;
   logic [126:0] rsp_data_o;
   logic         crc_err_o, idx_err_o, timeout_o;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   cmd_token_engine uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_idx_i(cmd_idx_i),
      .cmd_arg_i(cmd_arg_i), .rsp_kind_i(rsp_kind_i), .cmd_o(cmd_o),
      .cmd_oe_o(cmd_oe_o), .cmd_i(cmd_i), .busy_o(busy_o), .done_o(done_o),
      .rsp_idx_o(rsp_idx_o), .rsp_data_o(rsp_data_o), .crc_err_o(crc_err_o),
      .idx_err_o(idx_err_o), .timeout_o(timeout_o)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [135:0] act, input logic [135:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input logic [39:0] v);
      logic [6:0] c = '0;
      for (int i = 39; i >= 0; i--) begin
         logic fb = v[i] ^ c[6];
         c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic logic [135:0] mk_short(input logic [5:0] idx,
                                             input logic [31:0] st,
                                             input logic [6:0] mask);
      logic [39:0] body = {2'b00, idx, st};
      return 136'({body, crc7(body) ^ mask, 1'b1});
   endfunction

   // Sends one command; returns at the negedge following the last token bit.
   task automatic send(input logic [5:0] idx, input logic [31:0] arg,
                       input logic [1:0] kind, input bit poke);
      logic [47:0] tok, exp;
      bit oe_ok = 1'b1;
      exp = {1'b0, 1'b1, idx, arg, crc7({1'b0, 1'b1, idx, arg}), 1'b1};
      @(negedge clk);
      start_i = 1'b1; cmd_idx_i = idx; cmd_arg_i = arg; rsp_kind_i = kind;
      for (int k = 0; k < 48; k++) begin
         @(negedge clk);
         tok[47-k] = cmd_o;
         oe_ok &= cmd_oe_o;
         start_i   = poke && (k == 10);
         cmd_idx_i = (poke && k == 10) ? ~idx : idx;
      end
      @(negedge clk);
      chk(tok == exp, "R1 R2 token bits", 136'(tok), 136'(exp));
      chk(oe_ok && !cmd_oe_o && cmd_o, "R1 R3 drive window", 136'({oe_ok, cmd_oe_o, cmd_o}), 136'(3'b101));
      if (kind == 2'd0) begin
         chk(done_o == 1'b1 && !busy_o, "R4 done after token", 136'(done_o), 136'(1));
         @(negedge clk);
         chk(done_o == 1'b0, "R9 done single pulse", 136'(done_o), 136'(0));
      end
   endtask

   // Drives d idle cycles then the frame; returns at the negedge where done is expected.
   task automatic respond(input int d, input logic [135:0] fr, input int len);
      for (int i = 0; i < d; i++) begin
         cmd_i = 1'b1;
         @(negedge clk);
      end
      for (int j = len - 1; j >= 0; j--) begin
         cmd_i = fr[j];
         @(negedge clk);
      end
      cmd_i = 1'b1;
   endtask

   task automatic check_short(input string tag, input logic [5:0] eidx,
                              input logic [31:0] est, input bit ecrc, input bit eidxe);
      chk(done_o == 1'b1, {tag, " R9 done timing"}, 136'(done_o), 136'(1));
      chk(rsp_idx_o == eidx && rsp_data_o == 127'(est) && !timeout_o,
          {tag, " fields"}, 136'({rsp_idx_o, rsp_data_o}), 136'({eidx, 127'(est)}));
      chk(crc_err_o == ecrc && idx_err_o == eidxe, {tag, " flags"},
          136'({crc_err_o, idx_err_o}), 136'({ecrc, eidxe}));
      @(negedge clk);
      chk(!done_o && rsp_data_o == 127'(est), {tag, " R9 hold"},
          136'({done_o, rsp_data_o}), 136'({1'b0, 127'(est)}));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [5:0]   ix;
      logic [31:0]  st;
      logic [126:0] pay;
      bit           early;

      repeat (3) @(negedge clk);
      chk(cmd_o && !cmd_oe_o && !busy_o && !done_o, "R3 reset line idle",
          136'({cmd_o, cmd_oe_o, busy_o, done_o}), 136'(4'b1000));
      chk(rsp_data_o == '0 && !timeout_o && !crc_err_o, "R9 reset results",
          136'(rsp_data_o), 136'(0));
      rst_n = 1'b1;

      // Every index with no reply; index 5 also tries a start mid-token (R10).
      for (int i = 0; i < 64; i++)
         send(6'(i), 32'(i) * 32'h01030507 ^ 32'hA5C30F1E, 2'd0, i == 5);

      // Short replies across the whole wait window (R5, R6).
      for (int d = 0; d < 64; d++) begin
         ix = 6'((d * 7) % 64);
         st = 32'(d) * 32'h9E3779B9 + 32'h13579BDF;
         send(ix, ~st, 2'd1, d == 3);
         respond(d, mk_short(ix, st, 7'h00), 48);
         check_short((d == 3) ? "R10 R6 busy start ignored" : "R5 R6 short reply",
                     ix, st, 1'b0, 1'b0);
      end

      // No start bit inside the window (R5).
      send(6'd17, 32'h0, 2'd1, 1'b0);
      early = 1'b0;
      for (int i = 1; i < 64; i++) begin
         @(negedge clk);
         early |= done_o;
      end
      @(negedge clk);
      chk(!early && done_o && timeout_o && !crc_err_o && !idx_err_o, "R5 timeout at 64",
          136'({early, done_o, timeout_o, crc_err_o, idx_err_o}), 136'(5'b01100));

      // Corrupt each CRC bit (R6).
      for (int b = 0; b < 7; b++) begin
         send(6'd9, 32'h1, 2'd1, 1'b0);
         respond(b, mk_short(6'd9, 32'hCAFE0000 + 32'(b), 7'(1 << b)), 48);
         check_short("R6 crc bit flip", 6'd9, 32'hCAFE0000 + 32'(b), 1'b1, 1'b0);
      end
      // Corrupt a status bit with the old CRC (R6).
      send(6'd12, 32'h2, 2'd1, 1'b0);
      respond(2, mk_short(6'd12, 32'h0000F00D, 7'h00) ^ (136'(1) << 20), 48);
      check_short("R6 payload flip", 6'd12, 32'h0000F00D ^ 32'h1000, 1'b1, 1'b0);
      // Wrong echoed index, valid CRC (R6).
      send(6'd40, 32'h3, 2'd1, 1'b0);
      respond(5, mk_short(6'd41, 32'h12345678, 7'h00), 48);
      check_short("R6 index mismatch", 6'd41, 32'h12345678, 1'b0, 1'b1);

      // Unchecked short reply with index and CRC fields all ones (R7).
      send(6'd1, 32'h00FF8080, 2'd2, 1'b0);
      respond(4, 136'({2'b00, 6'h3F, 32'hC0FF8080, 7'h7F, 1'b1}), 48);
      check_short("R7 unchecked reply", 6'h3F, 32'hC0FF8080, 1'b0, 1'b0);

      // Next accept clears results (R9).
      send(6'd0, 32'h0, 2'd0, 1'b0);
      chk(rsp_data_o == '0 && rsp_idx_o == '0 && !crc_err_o, "R9 cleared on accept",
          136'(rsp_data_o), 136'(0));

      // Long replies (R8).
      for (int p = 0; p < 4; p++) begin
         pay = {4{32'(p) * 32'h2468ACE1 ^ 32'h5A5A5A5A}} >> p;
         pay[126] = p[0];
         send(6'd2 + 6'(p), 32'(p), 2'd3, 1'b0);
         respond(p * 9, {2'b00, 6'h3F, pay, 1'b1}, 136);
         chk(done_o == 1'b1, "R8 R9 long done timing", 136'(done_o), 136'(1));
         chk(rsp_data_o == pay && rsp_idx_o == '0 && !crc_err_o && !idx_err_o && !timeout_o,
             "R8 long payload", 136'(rsp_data_o), 136'(pay));
         repeat (5) @(negedge clk);
         chk(rsp_data_o == pay && !done_o, "R9 long hold", 136'(rsp_data_o), 136'(pay));
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule